// File: doc/BRIEF.md
# Floating-Point Relational Comparator

This block decides a relation between two floating-point values held as three 16-bit words each: an exponent word whose least significant bit carries the sign (1 means negative), a high mantissa word, and a low mantissa word. A caller presents both operands with a 3-bit relation mask and a valid strobe. One clock later the block returns a single true/false bit with its own valid strobe.

Internally the block first classifies the pair into exactly one of three outcomes, coded one-hot: first-greater is 3'b001, equal is 3'b010, first-less is 3'b100. The answer is true when the relation mask shares a set bit with that code. The usual masks are therefore greater = 1, greater-or-equal = 3, equal = 2, less-or-equal = 6, less = 4 and not-equal = 5. The ordering rules are deliberately cheap: an operand counts as zero when its high mantissa word alone is zero, and exponent words are ordered by a plain wrapping 16-bit subtraction rather than a true signed compare, so very distant exponents may order wrongly by design.

Top module: `fp_relcmp`

## Requirements
- R1: The result is true exactly when (mask AND outcome) is nonzero, with outcome codes greater = 3'b001, equal = 3'b010, less = 3'b100; mask 3'b000 always gives false and mask 3'b111 always gives true.
- R2: An operand is zero when its high mantissa word is zero, whatever its exponent and low word hold; when both operands are zero the outcome is equal.
- R3: When only the first operand is zero, the outcome is less if the second has sign bit 0 (exponent bit 0) and greater if it has sign bit 1.
- R4: When only the second operand is zero, the outcome is greater if the first has sign bit 0 and less if it has sign bit 1.
- R5: When both operands are nonzero and their sign bits differ, the operand with sign bit 0 is greater.
- R6: With equal signs and differing exponent words, the magnitude order is taken from bit 15 of the 16-bit wrapping difference (second exponent word minus first): bit 15 set means the first is larger in magnitude, clear means smaller.
- R7: With equal signs and equal exponent words, the high mantissa words are compared unsigned; if those are equal too, the low mantissa words are compared unsigned; all three equal gives the outcome equal.
- R8: When both operands are nonzero with sign bit 1, the magnitude order from R6 and R7 is reversed to give the outcome; equal stays equal.
- R9: The output valid strobe equals the input valid strobe delayed by exactly one clock, and the result bit for a request is presented in the same cycle as that strobe.
- R10: While the synchronous active-high reset is asserted, and in the first cycle after it, the output valid and result bit are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe for the operands and mask |
| a_exp | input | 16 | First operand exponent word, bit 0 is the sign |
| a_hi | input | 16 | First operand high mantissa word |
| a_lo | input | 16 | First operand low mantissa word |
| b_exp | input | 16 | Second operand exponent word, bit 0 is the sign |
| b_hi | input | 16 | Second operand high mantissa word |
| b_lo | input | 16 | Second operand low mantissa word |
| rel_mask | input | 3 | Relation mask: bit 0 greater, bit 1 equal, bit 2 less |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| out_true | output | 1 | Relation holds |

## Verification
The bench pushes every operand pair through all six relation masks, so a swapped outcome code or a wrong mask test shows up as a flipped bit on several masks at once. It targets mantissa words with the top bit set, where a signed instead of unsigned compare inverts the order, and negative pairs, where forgetting the reversal makes every less look greater. Two exponent pairs sit where the wrapping subtraction disagrees once with a true signed compare and once with an unsigned compare, so a design that "fixes" the exponent order is caught. Zero cases carry nonzero low words and exponents, which a design testing the whole value for zero would misreport as unequal.

// File: rtl/fp_relcmp_pkg.sv
package fp_relcmp_pkg;

  // One-hot ordering of the first operand against the second.
  typedef enum logic [2:0] {
    ORD_GT = 3'b001,
    ORD_EQ = 3'b010,
    ORD_LT = 3'b100
  } ord_e;

  // Reverse the sense of an ordering (used for negative operands).
  function automatic ord_e ord_flip(input ord_e o);
    case (o)
      ORD_GT:  return ORD_LT;
      ORD_LT:  return ORD_GT;
      default: return ORD_EQ;
    endcase
  endfunction

endpackage

// File: rtl/fp_relcmp_mag.sv
// Magnitude ordering of two operands that share a sign:
// exponent word by wrapping subtraction, then high, then low mantissa.
module fp_relcmp_mag
  import fp_relcmp_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] a_exp,
  input  logic [WORD_W-1:0] a_hi,
  input  logic [WORD_W-1:0] a_lo,
  input  logic [WORD_W-1:0] b_exp,
  input  logic [WORD_W-1:0] b_hi,
  input  logic [WORD_W-1:0] b_lo,
  output ord_e              mag_ord
);

  localparam int MSB = WORD_W - 1;

  logic [WORD_W-1:0] exp_diff;

  always_comb begin
    exp_diff = b_exp - a_exp;
    if (a_exp != b_exp) begin
      mag_ord = exp_diff[MSB] ? ORD_GT : ORD_LT;
    end else if (a_hi != b_hi) begin
      mag_ord = (a_hi > b_hi) ? ORD_GT : ORD_LT;
    end else if (a_lo != b_lo) begin
      mag_ord = (a_lo > b_lo) ? ORD_GT : ORD_LT;
    end else begin
      mag_ord = ORD_EQ;
    end
  end

endmodule

// File: rtl/fp_relcmp_order.sv
// Resolves zero and sign cases, then applies the magnitude order.
module fp_relcmp_order
  import fp_relcmp_pkg::*;
(
  input  logic a_zero,
  input  logic b_zero,
  input  logic a_neg,
  input  logic b_neg,
  input  ord_e mag_ord,
  output ord_e ord
);

  always_comb begin
    if (a_zero && b_zero) begin
      ord = ORD_EQ;
    end else if (a_zero) begin
      ord = b_neg ? ORD_GT : ORD_LT;
    end else if (b_zero) begin
      ord = a_neg ? ORD_LT : ORD_GT;
    end else if (a_neg != b_neg) begin
      ord = a_neg ? ORD_LT : ORD_GT;
    end else if (a_neg) begin
      ord = ord_flip(mag_ord);
    end else begin
      ord = mag_ord;
    end
  end

endmodule

// File: rtl/fp_relcmp.sv
module fp_relcmp
  import fp_relcmp_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int SIGN_POS = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] a_exp,
  input  logic [WORD_W-1:0] a_hi,
  input  logic [WORD_W-1:0] a_lo,
  input  logic [WORD_W-1:0] b_exp,
  input  logic [WORD_W-1:0] b_hi,
  input  logic [WORD_W-1:0] b_lo,
  input  logic [2:0]        rel_mask,
  output logic              out_valid,
  output logic              out_true
);

  localparam int NOPS = 2;

  logic [WORD_W-1:0] exp_w [NOPS];
  logic [WORD_W-1:0] hi_w  [NOPS];
  logic [NOPS-1:0]   op_zero;
  logic [NOPS-1:0]   op_neg;

  assign exp_w[0] = a_exp;
  assign exp_w[1] = b_exp;
  assign hi_w[0]  = a_hi;
  assign hi_w[1]  = b_hi;

  // Per-operand classification: zero from high word, sign from exponent.
  for (genvar g = 0; g < NOPS; g++) begin : g_cls
    assign op_zero[g] = (hi_w[g] == '0);
    assign op_neg[g]  = exp_w[g][SIGN_POS];
  end

  ord_e mag_ord;
  ord_e ord;

  fp_relcmp_mag #(.WORD_W(WORD_W)) u_mag (
    .a_exp   (a_exp),
    .a_hi    (a_hi),
    .a_lo    (a_lo),
    .b_exp   (b_exp),
    .b_hi    (b_hi),
    .b_lo    (b_lo),
    .mag_ord (mag_ord)
  );

  fp_relcmp_order u_order (
    .a_zero  (op_zero[0]),
    .b_zero  (op_zero[1]),
    .a_neg   (op_neg[0]),
    .b_neg   (op_neg[1]),
    .mag_ord (mag_ord),
    .ord     (ord)
  );

  logic hit;
  assign hit = |(rel_mask & ord);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_true  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_true  <= hit;
    end
  end

endmodule

// File: rtl/fp_relcmp_chk.sv
module fp_relcmp_chk #(
  parameter int WORD_W   = 16,
  parameter int SIGN_POS = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [WORD_W-1:0] a_exp,
  input logic [WORD_W-1:0] a_hi,
  input logic [WORD_W-1:0] b_exp,
  input logic [WORD_W-1:0] b_hi,
  input logic [2:0]        rel_mask,
  input logic              out_valid,
  input logic              out_true
);

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_follows_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_empty_mask_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rel_mask == 3'b000) |=> !out_true);

  assert_full_mask_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rel_mask == 3'b111) |=> out_true);

  assert_both_zero_equal_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && a_hi == '0 && b_hi == '0 && rel_mask == 3'b010) |=> out_true);

  assert_first_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && a_hi == '0 && b_hi != '0 && !b_exp[SIGN_POS] && rel_mask == 3'b100)
      |=> out_true);

  assert_sign_split_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && a_hi != '0 && b_hi != '0 && !a_exp[SIGN_POS] && b_exp[SIGN_POS]
     && rel_mask == 3'b001) |=> out_true);

  assert_reset_clear_R10: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !out_true));

endmodule

bind fp_relcmp fp_relcmp_chk #(.WORD_W(WORD_W), .SIGN_POS(SIGN_POS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .a_exp     (a_exp),
  .a_hi      (a_hi),
  .b_exp     (b_exp),
  .b_hi      (b_hi),
  .rel_mask  (rel_mask),
  .out_valid (out_valid),
  .out_true  (out_true)
);

// File: tb/test_fp_relcmp.sv
module test_fp_relcmp;

  localparam int W    = 16;
  localparam int NVEC = 20;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] a_exp = '0, a_hi = '0, a_lo = '0;
  logic [W-1:0] b_exp = '0, b_hi = '0, b_lo = '0;
  logic [2:0]   rel_mask = '0;
  logic         out_valid;
  logic         out_true;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  fp_relcmp i_fp_relcmp (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_exp(a_exp), .a_hi(a_hi), .a_lo(a_lo),
    .b_exp(b_exp), .b_hi(b_hi), .b_lo(b_lo),
    .rel_mask(rel_mask), .out_valid(out_valid), .out_true(out_true)
  );

  // {a_exp, a_hi, a_lo, b_exp, b_hi, b_lo, expected outcome code}
  // outcome codes: 1 greater, 2 equal, 4 less
  localparam logic [98:0] VECS [NVEC] = '{
    {16'h0010, 16'h0000, 16'h1234, 16'h0033, 16'h0000, 16'h0000, 3'd2},
    {16'h0000, 16'h0000, 16'h0000, 16'h0010, 16'h8000, 16'h0000, 3'd4},
    {16'h0000, 16'h0000, 16'h0000, 16'h0011, 16'h8000, 16'h0000, 3'd1},
    {16'h0010, 16'h8000, 16'h0000, 16'h0020, 16'h0000, 16'h5555, 3'd1},
    {16'h0011, 16'h8000, 16'h0000, 16'h0020, 16'h0000, 16'h5555, 3'd4},
    {16'h0010, 16'h8000, 16'h0000, 16'h0041, 16'hC000, 16'h0000, 3'd1},
    {16'h0041, 16'hC000, 16'h0000, 16'h0010, 16'h8000, 16'h0000, 3'd4},
    {16'h0020, 16'h8000, 16'h0000, 16'h0010, 16'hFFFF, 16'hFFFF, 3'd1},
    {16'h0010, 16'hFFFF, 16'hFFFF, 16'h0020, 16'h8000, 16'h0000, 3'd4},
    {16'h0021, 16'h8000, 16'h0000, 16'h0011, 16'hFFFF, 16'hFFFF, 3'd4},
    {16'h0010, 16'hF000, 16'h0000, 16'h0010, 16'h8000, 16'hFFFF, 3'd1},
    {16'h0010, 16'h9000, 16'h8001, 16'h0010, 16'h9000, 16'h7FFF, 3'd1},
    {16'h0010, 16'h9000, 16'h0001, 16'h0010, 16'h9000, 16'hFFFE, 3'd4},
    {16'h0011, 16'hF000, 16'h0000, 16'h0011, 16'h8000, 16'h0000, 3'd4},
    {16'h0011, 16'h9000, 16'h0001, 16'h0011, 16'h9000, 16'h0002, 3'd1},
    {16'h0010, 16'h9000, 16'h1234, 16'h0010, 16'h9000, 16'h1234, 3'd2},
    {16'h0011, 16'hA000, 16'h00FF, 16'h0011, 16'hA000, 16'h00FF, 3'd2},
    {16'h9000, 16'h8000, 16'h0000, 16'h1000, 16'h8000, 16'h0000, 3'd1},
    {16'h0000, 16'h8000, 16'h0000, 16'h9000, 16'h8000, 16'h0000, 3'd1},
    {16'h0010, 16'h0000, 16'hFFFF, 16'h0011, 16'h0000, 16'h0001, 3'd2}
  };

  string TAGS [NVEC] = '{
    "R2", "R3", "R3", "R4", "R4", "R5", "R5", "R6", "R6", "R8",
    "R7", "R7", "R7", "R8", "R8", "R7", "R8", "R6", "R6", "R2"
  };

  // less, equal, greater, less-or-equal, not-equal, greater-or-equal
  localparam logic [2:0] MASKS [6] = '{3'd4, 3'd2, 3'd1, 3'd6, 3'd5, 3'd3};

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // Drive one request; check the registered result one clock later.
  task automatic request(input logic [98:0] v, input logic [2:0] m,
                         input string tag, input logic exp_true);
    @(negedge clk);
    {a_exp, a_hi, a_lo, b_exp, b_hi, b_lo} = v[98:3];
    rel_mask = m;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit({tag, " valid R9"}, out_valid, 1'b1);
    check_bit({tag, " result R1"}, out_true, exp_true);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R10: reset state, during and right after reset
    repeat (3) @(negedge clk);
    check_bit("R10 valid in reset", out_valid, 1'b0);
    check_bit("R10 result in reset", out_true, 1'b0);
    in_valid = 1'b1;
    rel_mask = 3'b111;
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check_bit("R10 valid after reset", out_valid, 1'b0);

    // Table walk: every vector against every relation mask
    for (int i = 0; i < NVEC; i++) begin
      for (int m = 0; m < 6; m++) begin
        request(VECS[i], MASKS[m], TAGS[i], |(MASKS[m] & VECS[i][2:0]));
      end
    end

    // R1: empty mask never true, full mask always true
    request(VECS[7], 3'b000, "R1 empty", 1'b0);
    request(VECS[15], 3'b000, "R1 empty", 1'b0);
    request(VECS[9], 3'b111, "R1 full", 1'b1);
    request(VECS[0], 3'b111, "R1 full", 1'b1);

    // R9: valid drops one clock after the request strobe drops
    @(negedge clk);
    check_bit("R9 idle", out_valid, 1'b0);

    // R9: back-to-back requests each get a strobe and their own result
    @(negedge clk);
    {a_exp, a_hi, a_lo, b_exp, b_hi, b_lo} = VECS[7][98:3];
    rel_mask = 3'd1;
    in_valid = 1'b1;
    @(negedge clk);
    check_bit("R9 stream first valid", out_valid, 1'b1);
    check_bit("R9 stream first result", out_true, 1'b1);
    {a_exp, a_hi, a_lo, b_exp, b_hi, b_lo} = VECS[8][98:3];
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R9 stream second valid", out_valid, 1'b1);
    check_bit("R9 stream second result", out_true, 1'b0);
    @(negedge clk);
    check_bit("R9 stream end", out_valid, 1'b0);

    // R10: reset in mid-run clears the outputs
    {a_exp, a_hi, a_lo, b_exp, b_hi, b_lo} = VECS[15][98:3];
    rel_mask = 3'd2;
    in_valid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check_bit("R10 mid-run valid", out_valid, 1'b0);
    check_bit("R10 mid-run result", out_true, 1'b0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    finish_run();
  end

endmodule